// File: doc/BRIEF.md
# SDRAM and ROM Bus Trace Capture

This block sits passively beside a microcontroller's memory interfaces and turns the activity it sees into trace records. On the SDRAM side it waits for the controller's data-valid strobe. On each clock edge where that strobe is high, it takes the bank, address, data, code-fetch and bus-master pins. It then rebuilds a full 28-bit byte address. The row part of that address was stored per bank when an ACTIVATE command was seen. The column width comes from a configuration input. Because the block relies only on the strobe, it never needs to know the SDRAM timing programmed into the controller.

On the ROM and general-purpose memory bus, each read strobe is active low. When a strobe is released, the block emits a record that marks the access as either an instruction fetch or a data read. All records go into a small FIFO, which a trace consumer drains through a valid/ready port. If a record has to be lost, because the FIFO is full or because two sources produce a record in the same cycle, a sticky overflow flag is set.

Top module: `bus_trace_capture`

## Requirements
- R1: An SDRAM record is produced only on a rising clock edge at which `dataValid` is sampled high. It carries the bank, address, data and `sdramCodeN` values sampled at that edge, with fetch bit = NOT `sdramCodeN`. When `dataValid` is low, no SDRAM record is produced, whatever the other pins do.
- R2: The kind field of an SDRAM record is 1 (write) when the WRITE command (`rasN`=1, `casN`=0, `weN`=0) is on the command pins at the strobed edge, and 0 (read) otherwise. An unstrobed read phase before a write, as in a read-modify-write, therefore yields only the write record.
- R3: SDRAM write records carry `busMaster` as sampled at the strobed edge (1 = DMA or external master took part, 0 = CPU alone). Read records carry master = 0.
- R4: An ACTIVATE command (`rasN`=0, `casN`=1, `weN`=1) stores `memAddr` as the open row of the bank selected by `bankAddr`. Each bank keeps its own row.
- R5: The record address is {row, bank, column, 2'b00}, zero-extended or truncated to 28 bits. The column width is 8 + `colSel` (8 to 11 bits). The column is the low column-width bits of `memAddr` at the strobed edge, and `memAddr` bits above the column width are ignored.
- R6: At the first clock edge at which `romRdN` (or `gpRdN`) is sampled high after having been sampled low, a record is produced with kind 2 (ROM) or kind 3 (GP), fetch = NOT `romGpCodeN` sampled at that edge, and master, address and data all zero. `romGpCodeN` has no effect at any other time.
- R7: Records leave in arrival order through a FIFO of 16 entries. `recValid` is high while the FIFO holds a record, and a record is removed at each clock edge where `recValid` and `recReady` are both high.
- R8: A record that arrives while the FIFO is full is dropped and sets `overflow`. `overflow` stays high until a cycle with `ovfClear` high and no new loss in that cycle.
- R9: At most one record is accepted per cycle, with priority SDRAM > ROM > GP. A record that loses this arbitration is dropped and sets `overflow`.
- R10: A synchronous active-high `rst` empties the FIFO, clears `overflow` and sets every bank's stored row to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| dataValid | input | 1 | SDRAM data-valid strobe |
| busMaster | input | 1 | High when a DMA or external master took part in the write |
| sdramCodeN | input | 1 | SDRAM code-fetch flag, low = instruction fetch |
| bankAddr | input | 2 | SDRAM bank select |
| memAddr | input | 13 | Multiplexed SDRAM row/column address |
| memData | input | 32 | SDRAM data bus |
| rasN | input | 1 | SDRAM row strobe command pin |
| casN | input | 1 | SDRAM column strobe command pin |
| weN | input | 1 | SDRAM write-enable command pin |
| romRdN | input | 1 | ROM read strobe, active low |
| gpRdN | input | 1 | General-purpose bus memory read strobe, active low |
| romGpCodeN | input | 1 | ROM/GP code-fetch flag, low = instruction fetch |
| colSel | input | 2 | Column width select, width = 8 + colSel |
| recReady | input | 1 | Consumer accepts the head record |
| ovfClear | input | 1 | Clears the sticky overflow flag |
| recValid | output | 1 | A record is available |
| recKind | output | 2 | 0 SDRAM read, 1 SDRAM write, 2 ROM, 3 GP |
| recFetch | output | 1 | 1 = instruction fetch, 0 = data access |
| recMaster | output | 1 | Master flag of an SDRAM write record |
| recAddr | output | 28 | Rebuilt byte address (zero for ROM/GP) |
| recData | output | 32 | Captured data (zero for ROM/GP) |
| overflow | output | 1 | Sticky record-loss flag |

## Verification
Several behaviours are checked by assertions on every cycle. These are: the FIFO draining one entry per accepted pop, the overflow flag being set after a full-FIFO push or a same-cycle collision, the flag staying set until it is cleared, the reset result, and ROM/GP records appearing only at a strobe release. Other behaviours need the bench's scenarios. These are: the exact rebuilt address for each column width and bank, the per-bank row memory, the read/write and master tagging, and the absence of records for unstrobed SDRAM beats or for a flag that toggles with no strobe. A scoreboard shows them by comparing every record the port emits with one predicted from the pins that were driven.

// File: rtl/bus_trace_pkg.sv
package bus_trace_pkg;
  localparam int BANK_W = 2;
  localparam int MA_W = 13;
  localparam int DATA_W = 32;
  localparam int TRACE_ADDR_W = 28;
  localparam int NUM_BANKS = 1 << BANK_W;

  typedef enum logic [1:0] {
    REC_SD_READ  = 2'd0,
    REC_SD_WRITE = 2'd1,
    REC_ROM      = 2'd2,
    REC_GP       = 2'd3
  } recKind_t;

  typedef struct packed {
    recKind_t                 kind;
    logic                     fetch;
    logic                     master;
    logic [TRACE_ADDR_W-1:0]  addr;
    logic [DATA_W-1:0]        data;
  } traceRec_t;

  typedef struct packed {
    logic rowLoad;
    logic sdPush;
    logic sdWrite;
    logic romPush;
    logic gpPush;
    logic clash;
  } ctrlStrobe_t;
endpackage

// File: rtl/trace_ctrl.sv
module trace_ctrl
  import bus_trace_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        dataValid,
  input  logic        rasN,
  input  logic        casN,
  input  logic        weN,
  input  logic        romRdN,
  input  logic        gpRdN,
  output ctrlStrobe_t strobes
);
  logic prevRomN;
  logic prevGpN;
  logic romRise;
  logic gpRise;
  logic writeCmd;
  logic actCmd;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevRomN <= 1'b1;
      prevGpN  <= 1'b1;
    end else begin
      prevRomN <= romRdN;
      prevGpN  <= gpRdN;
    end
  end

  always_comb begin
    writeCmd = rasN & ~casN & ~weN;
    actCmd   = ~rasN & casN & weN;
    romRise  = ~prevRomN & romRdN;
    gpRise   = ~prevGpN & gpRdN;

    strobes.rowLoad = actCmd;
    strobes.sdPush  = dataValid;
    strobes.sdWrite = writeCmd;
    strobes.romPush = romRise & ~dataValid;
    strobes.gpPush  = gpRise & ~dataValid & ~romRise;
    strobes.clash   = (dataValid & (romRise | gpRise)) | (romRise & gpRise);
  end

  // R6
  rom_edge_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.romPush |-> ($past(romRdN) == 1'b0 && romRdN));

  // R6
  gp_edge_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.gpPush |-> ($past(gpRdN) == 1'b0 && gpRdN));
endmodule

// File: rtl/trace_fifo.sv
module trace_fifo #(
  parameter int WIDTH = 64,
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty,
  output logic [CNT_W-1:0] level
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic pushEn;
  logic popEn;

  assign full   = (level == CNT_W'(DEPTH));
  assign empty  = (level == '0);
  assign pushEn = push & ~full;
  assign popEn  = pop & ~empty;
  assign dout   = store[rdPtr];

  always_ff @(posedge clk) begin
    if (pushEn) store[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (pushEn) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (popEn)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({pushEn, popEn})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  // R7
  fifo_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (popEn && !pushEn) |=> (level == $past(level) - 1'b1));
endmodule

// File: rtl/trace_datapath.sv
module trace_datapath
  import bus_trace_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int COL_MIN = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ctrlStrobe_t          strobes,
  input  logic [BANK_W-1:0]    bankAddr,
  input  logic [MA_W-1:0]      memAddr,
  input  logic [DATA_W-1:0]    memData,
  input  logic                 busMaster,
  input  logic                 sdramCodeN,
  input  logic                 romGpCodeN,
  input  logic [1:0]           colSel,
  input  logic                 recReady,
  input  logic                 ovfClear,
  output traceRec_t            headRec,
  output logic                 recValid,
  output logic                 overflow
);
  localparam int REC_W = $bits(traceRec_t);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int WIDE_W = 64;

  logic [NUM_BANKS-1:0][MA_W-1:0] rowReg;
  logic [3:0]        colWidth;
  logic [MA_W-1:0]   colVal;
  logic [MA_W-1:0]   curRow;
  logic [WIDE_W-1:0] wideAddr;
  traceRec_t         newRec;
  logic              anyPush;
  logic              fifoFull;
  logic              fifoEmpty;
  logic [CNT_W-1:0]  fifoLevel;
  logic [REC_W-1:0]  fifoOut;
  logic              lossNow;

  always_ff @(posedge clk) begin
    if (rst) begin
      rowReg <= '0;
    end else if (strobes.rowLoad) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (bankAddr == BANK_W'(b)) rowReg[b] <= memAddr;
      end
    end
  end

  always_comb begin
    colWidth = 4'(COL_MIN) + {2'b00, colSel};
    colVal   = memAddr & ((MA_W'(1) << colWidth) - MA_W'(1));
    curRow   = rowReg[bankAddr];
    wideAddr = (WIDE_W'(curRow) << (colWidth + 4'd4))
             | (WIDE_W'(bankAddr) << (colWidth + 4'd2))
             | (WIDE_W'(colVal) << 2);
  end

  always_comb begin
    newRec = '0;
    if (strobes.sdPush) begin
      newRec.kind   = strobes.sdWrite ? REC_SD_WRITE : REC_SD_READ;
      newRec.fetch  = ~sdramCodeN;
      newRec.master = strobes.sdWrite & busMaster;
      newRec.addr   = wideAddr[TRACE_ADDR_W-1:0];
      newRec.data   = memData;
    end else if (strobes.romPush) begin
      newRec.kind  = REC_ROM;
      newRec.fetch = ~romGpCodeN;
    end else if (strobes.gpPush) begin
      newRec.kind  = REC_GP;
      newRec.fetch = ~romGpCodeN;
    end
  end

  assign anyPush = strobes.sdPush | strobes.romPush | strobes.gpPush;
  assign lossNow = (anyPush & fifoFull) | strobes.clash;

  trace_fifo #(
    .WIDTH(REC_W),
    .DEPTH(FIFO_DEPTH),
    .CNT_W(CNT_W)
  ) recQueue (
    .clk(clk),
    .rst(rst),
    .push(anyPush),
    .din(REC_W'(newRec)),
    .pop(recReady),
    .dout(fifoOut),
    .full(fifoFull),
    .empty(fifoEmpty),
    .level(fifoLevel)
  );

  assign headRec  = traceRec_t'(fifoOut);
  assign recValid = ~fifoEmpty;

  always_ff @(posedge clk) begin
    if (rst)           overflow <= 1'b0;
    else if (lossNow)  overflow <= 1'b1;
    else if (ovfClear) overflow <= 1'b0;
  end

  // R8
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (fifoFull && anyPush) |=> overflow);

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (overflow && !ovfClear) |=> overflow);

  // R9
  clash_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.sdPush && (strobes.romPush || strobes.gpPush)) |-> 1'b0);

  // R9
  clash_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.clash |=> overflow);

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (fifoLevel == '0 && !overflow));
endmodule

// File: rtl/bus_trace_capture.sv
module bus_trace_capture
  import bus_trace_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int COL_MIN = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        dataValid,
  input  logic        busMaster,
  input  logic        sdramCodeN,
  input  logic [1:0]  bankAddr,
  input  logic [12:0] memAddr,
  input  logic [31:0] memData,
  input  logic        rasN,
  input  logic        casN,
  input  logic        weN,
  input  logic        romRdN,
  input  logic        gpRdN,
  input  logic        romGpCodeN,
  input  logic [1:0]  colSel,
  input  logic        recReady,
  input  logic        ovfClear,
  output logic        recValid,
  output logic [1:0]  recKind,
  output logic        recFetch,
  output logic        recMaster,
  output logic [27:0] recAddr,
  output logic [31:0] recData,
  output logic        overflow
);
  ctrlStrobe_t strobes;
  traceRec_t   headRec;

  trace_ctrl ctrl (
    .clk(clk),
    .rst(rst),
    .dataValid(dataValid),
    .rasN(rasN),
    .casN(casN),
    .weN(weN),
    .romRdN(romRdN),
    .gpRdN(gpRdN),
    .strobes(strobes)
  );

  trace_datapath #(
    .FIFO_DEPTH(FIFO_DEPTH),
    .COL_MIN(COL_MIN)
  ) dpath (
    .clk(clk),
    .rst(rst),
    .strobes(strobes),
    .bankAddr(bankAddr),
    .memAddr(memAddr),
    .memData(memData),
    .busMaster(busMaster),
    .sdramCodeN(sdramCodeN),
    .romGpCodeN(romGpCodeN),
    .colSel(colSel),
    .recReady(recReady),
    .ovfClear(ovfClear),
    .headRec(headRec),
    .recValid(recValid),
    .overflow(overflow)
  );

  assign recKind   = headRec.kind;
  assign recFetch  = headRec.fetch;
  assign recMaster = headRec.master;
  assign recAddr   = headRec.addr;
  assign recData   = headRec.data;
endmodule

// File: tb/bus_trace_capture_test.sv
module bus_trace_capture_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dataValid = 1'b0, busMaster = 1'b0, sdramCodeN = 1'b1;
  logic [1:0] bankAddr = '0;
  logic [12:0] memAddr = '0;
  logic [31:0] memData = '0;
  logic rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic romRdN = 1'b1, gpRdN = 1'b1, romGpCodeN = 1'b1;
  logic [1:0] colSel = '0;
  logic recReady = 1'b0, ovfClear = 1'b0;
  logic recValid, recFetch, recMaster, overflow;
  logic [1:0] recKind;
  logic [27:0] recAddr;
  logic [31:0] recData;
  logic [63:0] got;

  int nChecks = 0;
  int nFail = 0;
  logic [12:0] rowModel [4];
  logic [63:0] expQ [$];
  string tagQ [$];

  always #10 clk = ~clk;

  bus_trace_capture uut (
    .clk(clk), .rst(rst), .dataValid(dataValid), .busMaster(busMaster),
    .sdramCodeN(sdramCodeN), .bankAddr(bankAddr), .memAddr(memAddr),
    .memData(memData), .rasN(rasN), .casN(casN), .weN(weN),
    .romRdN(romRdN), .gpRdN(gpRdN), .romGpCodeN(romGpCodeN),
    .colSel(colSel), .recReady(recReady), .ovfClear(ovfClear),
    .recValid(recValid), .recKind(recKind), .recFetch(recFetch),
    .recMaster(recMaster), .recAddr(recAddr), .recData(recData),
    .overflow(overflow)
  );

  assign got = {recKind, recFetch, recMaster, recAddr, recData};

  task automatic check(input logic ok, input string tag,
                       input logic [63:0] act, input logic [63:0] want);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, want);
    end
  endtask

  function automatic logic [27:0] mkAddr(input logic [12:0] row,
      input logic [1:0] bank, input logic [12:0] ma, input logic [1:0] cs);
    int cw;
    logic [63:0] v;
    cw = 8 + int'(cs);
    v = (64'(row) << (cw + 4)) + (64'(bank) << (cw + 2))
      + (64'(ma & 13'((1 << cw) - 1)) << 2);
    return v[27:0];
  endfunction

  task automatic step;
    @(posedge clk);
    #4;
  endtask

  task automatic nopCmd;
    rasN = 1'b1; casN = 1'b1; weN = 1'b1;
  endtask

  task automatic activate(input logic [1:0] bk, input logic [12:0] row);
    rasN = 1'b0; casN = 1'b1; weN = 1'b1;
    bankAddr = bk; memAddr = row;
    rowModel[bk] = row;
    step;
    nopCmd;
  endtask

  task automatic sdBeat(input bit wr, input logic [1:0] bk, input logic [12:0] ma,
      input logic [31:0] d, input bit codeN, input bit mst, input bit expectIt,
      input string tag);
    dataValid = 1'b1; bankAddr = bk; memAddr = ma; memData = d;
    sdramCodeN = codeN; busMaster = mst;
    if (wr) begin rasN = 1'b1; casN = 1'b0; weN = 1'b0; end
    else nopCmd;
    if (expectIt) begin
      expQ.push_back({(wr ? 2'd1 : 2'd0), ~codeN, (wr ? mst : 1'b0),
                      mkAddr(rowModel[bk], bk, ma, colSel), d});
      tagQ.push_back(tag);
    end
    step;
    dataValid = 1'b0;
    nopCmd;
  endtask

  task automatic romAcc(input bit gp, input bit codeN, input string tag);
    if (gp) gpRdN = 1'b0; else romRdN = 1'b0;
    romGpCodeN = ~codeN;
    step;
    step;
    if (gp) gpRdN = 1'b1; else romRdN = 1'b1;
    romGpCodeN = codeN;
    expQ.push_back({(gp ? 2'd3 : 2'd2), ~codeN, 1'b0, 28'd0, 32'd0});
    tagQ.push_back(tag);
    step;
    romGpCodeN = ~codeN;
    step;
  endtask

  always @(negedge clk) begin
    if (!rst && recValid && recReady) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R1 unexpected record", got, 64'd0);
      end else begin
        logic [63:0] want;
        string tag;
        want = expQ.pop_front();
        tag = tagQ.pop_front();
        check(got == want, tag, got, want);
      end
    end
  end

  initial begin
    #4000000;
    check(1'b0, "watchdog expired", 64'd0, 64'd1);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) rowModel[i] = '0;
    repeat (3) step;
    rst = 1'b0;
    check(recValid == 1'b0, "R10 reset recValid", 64'(recValid), 64'd0);
    check(overflow == 1'b0, "R10 reset overflow", 64'(overflow), 64'd0);
    recReady = 1'b1;

    // R10: rows start at zero; R5 column width 8
    sdBeat(0, 2'd2, 13'h005, 32'h1111_2222, 1, 0, 1, "R10 R5 read with zero row");
    // R4 per-bank rows; R3 master tagging; R1 fetch flag
    activate(2'd0, 13'h1ABC);
    activate(2'd1, 13'h0123);
    sdBeat(1, 2'd0, 13'h0A5, 32'hDEAD_BEEF, 1, 1, 1, "R4 R3 write bank0 master");
    sdBeat(0, 2'd1, 13'h03F, 32'hCAFE_F00D, 0, 1, 1, "R3 R1 read fetch master zero");
    sdBeat(1, 2'd1, 13'h011, 32'h0000_0042, 1, 0, 1, "R3 write cpu only");
    // R5 other column widths with upper address bits set
    colSel = 2'd3;
    sdBeat(1, 2'd1, 13'h1FFF, 32'h1234_5678, 1, 0, 1, "R5 col width 11");
    colSel = 2'd1;
    sdBeat(0, 2'd0, 13'h1FFF, 32'h8765_4321, 0, 0, 1, "R5 col width 9");
    colSel = 2'd2;
    sdBeat(0, 2'd3, 13'h0155, 32'h0BAD_F00D, 1, 0, 1, "R5 col width 10");
    colSel = 2'd0;
    // R2 read-modify-write: unstrobed read phase then write beat
    rasN = 1'b1; casN = 1'b0; weN = 1'b1; bankAddr = 2'd0; memAddr = 13'h010;
    step;
    nopCmd;
    step;
    sdBeat(1, 2'd0, 13'h010, 32'h5555_AAAA, 1, 0, 1, "R2 rmw write only");
    // R1 write command with data but no strobe
    rasN = 1'b1; casN = 1'b0; weN = 1'b0; memData = 32'hFFFF_0000;
    step;
    nopCmd;
    repeat (3) step;
    // R6 ROM fetch and GP data read; flag toggles without strobe
    romAcc(0, 0, "R6 rom instruction fetch");
    romAcc(1, 1, "R6 gp data read");
    romGpCodeN = 1'b0; step; romGpCodeN = 1'b1; step; romGpCodeN = 1'b0; step;
    repeat (3) step;
    check(expQ.size() == 0, "R6 flag alone made no record", 64'(expQ.size()), 64'd0);
    check(overflow == 1'b0, "R9 no loss yet", 64'(overflow), 64'd0);
    // R9 collision: SDRAM beat and ROM release in the same cycle
    romRdN = 1'b0;
    step;
    romRdN = 1'b1;
    sdBeat(1, 2'd1, 13'h022, 32'hA5A5_5A5A, 1, 1, 1, "R9 sdram wins collision");
    check(overflow == 1'b1, "R9 collision sets overflow", 64'(overflow), 64'd1);
    repeat (3) step;
    check(overflow == 1'b1, "R8 overflow sticky", 64'(overflow), 64'd1);
    ovfClear = 1'b1;
    step;
    ovfClear = 1'b0;
    check(overflow == 1'b0, "R8 clear", 64'(overflow), 64'd0);
    // R8 fill FIFO without draining
    repeat (4) step;
    recReady = 1'b0;
    for (int i = 0; i < 17; i++)
      sdBeat(1, 2'd0, 13'(i), 32'(i * 7 + 1), 1, 0, (i < 16), "R8 R7 fifo order");
    step;
    check(overflow == 1'b1, "R8 full drop sets overflow", 64'(overflow), 64'd1);
    check(recValid == 1'b1, "R7 valid while holding", 64'(recValid), 64'd1);
    recReady = 1'b1;
    repeat (24) step;
    check(expQ.size() == 0, "R7 drained sixteen", 64'(expQ.size()), 64'd0);
    check(recValid == 1'b0, "R7 empty after drain", 64'(recValid), 64'd0);
    // R10 reset flushes pending record and clears rows
    recReady = 1'b0;
    sdBeat(0, 2'd0, 13'h001, 32'h0, 1, 0, 0, "R10 flushed");
    rst = 1'b1;
    step;
    rst = 1'b0;
    for (int i = 0; i < 4; i++) rowModel[i] = '0;
    check(recValid == 1'b0, "R10 flush recValid", 64'(recValid), 64'd0);
    check(overflow == 1'b0, "R10 flush overflow", 64'(overflow), 64'd0);
    recReady = 1'b1;
    sdBeat(0, 2'd0, 13'h0F0, 32'h7777_7777, 1, 0, 1, "R10 row cleared by reset");
    repeat (6) step;
    check(expQ.size() == 0, "R7 final drain", 64'(expQ.size()), 64'd0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule